// File: doc/BRIEF.md
# Trace Status Register Access Gate

This block decides, for one access to a protected trace status register, whether the access is allowed, whether it is an undefined instruction, or whether it traps to a higher privilege level. The caller presents the current privilege level, whether levels 2 and 3 are implemented and running in 64-bit state, the security state, and two 2-bit trace control fields: one owned by level 2 and one owned by level 3. The block returns a one-hot verdict, plus the target level and a fixed exception class when the verdict is a trap. Reads and writes follow the same rules, so the block has no direction input. Carrying out the trap is the caller's job.

The checks run in a fixed priority order. At level 1, the trap to level 2 is checked first. The level-3 checks come next. Their pass code depends on the security state. The decision is registered once. The outputs therefore show the inputs from the previous rising clock edge.

Top module: `trc_access_gate`

## Requirements
- R1: While rst_ni is low, allow_o, undef_o, trap_o, trap_el_o and trap_class_o are all zero.
- R2: An access at privilege level 0 (cur_el_i = 0) gives undef_o = 1, whatever the other inputs are.
- R3: At level 1, if el2_on_i = 1 and bit 0 of l2_ctl_i is 0, the access traps to level 2 (trap_el_o = 2). Bit 1 of l2_ctl_i is ignored. This check takes priority over every level-3 check.
- R4: At levels 1 and 2, when el3_on_i = 1 and ns_i = 0, the access traps to level 3 (trap_el_o = 3) unless l3_ctl_i = 2'b01.
- R5: At levels 1 and 2, when el3_on_i = 1 and ns_i = 1, the access traps to level 3 unless l3_ctl_i = 2'b11.
- R6: When el3_on_i = 0, no level-3 check applies. An access at level 1 or 2 that is not caught by R3 is allowed.
- R7: An access at level 3 is always allowed.
- R8: After the first clock out of reset, exactly one of allow_o, undef_o and trap_o is 1. When trap_o = 1, trap_class_o = 6'h18. When trap_o = 0, both trap_class_o and trap_el_o are 0.
- R9: Each output shows the inputs sampled at the previous rising edge of clk_i. A change on the inputs does not reach the outputs before the next edge.
- R10: At level 2, el2_on_i and l2_ctl_i have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_el_i | input | 2 | Privilege level of the access (0 to 3) |
| el2_on_i | input | 1 | Level 2 is enabled and runs in 64-bit state |
| el3_on_i | input | 1 | Level 3 is implemented and runs in 64-bit state |
| ns_i | input | 1 | Security state: 1 is non-secure |
| l2_ctl_i | input | 2 | Trace control field owned by level 2 |
| l3_ctl_i | input | 2 | Trace control field owned by level 3 |
| allow_o | output | 1 | Access is allowed |
| undef_o | output | 1 | Access is an undefined instruction |
| trap_o | output | 1 | Access traps to a higher level |
| trap_el_o | output | 2 | Target level of the trap, 0 when not trapping |
| trap_class_o | output | 6 | Exception class of the trap, 0 when not trapping |

## Verification
The bench builds the block with its default parameters: a 6-bit class of 0x18, pass code 01 in secure state and pass code 11 in non-secure state. The full input space is only 512 combinations, so every one of them is driven in sequence. This reaches every priority collision: a level-2 trap hiding a level-3 failure, bit 1 of the level-2 field toggling, and the level-2 controls changing at level 2. Latency is checked by sampling the outputs between an input change and the next edge. A mid-run reset checks the cleared state.

// File: rtl/trc_gate_pkg.sv
package trc_gate_pkg;
  localparam int unsigned EL_W  = 2;
  localparam int unsigned CTL_W = 2;

  typedef enum logic [1:0] {
    VERD_ALLOW = 2'd0,
    VERD_UNDEF = 2'd1,
    VERD_TRAP  = 2'd2
  } verdict_e;

  typedef struct packed {
    verdict_e          verd;
    logic [EL_W-1:0]   tgt;
  } decision_t;

  localparam logic [EL_W-1:0] EL_USER  = 2'd0;
  localparam logic [EL_W-1:0] EL_KERN  = 2'd1;
  localparam logic [EL_W-1:0] EL_HYP   = 2'd2;
  localparam logic [EL_W-1:0] EL_MON   = 2'd3;
endpackage

// File: rtl/trc_lower_gate.sv
module trc_lower_gate
  import trc_gate_pkg::*;
(
  input  logic [EL_W-1:0]  cur_el_i,
  input  logic             el2_on_i,
  input  logic [CTL_W-1:0] l2_ctl_i,
  output logic             hit_o
);
  // only bit 0 of the level-2 field gates access; bit 1 is don't-care
  always_comb hit_o = (cur_el_i == EL_KERN) && el2_on_i && !l2_ctl_i[0];
endmodule

// File: rtl/trc_upper_gate.sv
module trc_upper_gate
  import trc_gate_pkg::*;
#(
  parameter logic [CTL_W-1:0] SEC_PASS  = 2'b01,
  parameter logic [CTL_W-1:0] NSEC_PASS = 2'b11
) (
  input  logic [EL_W-1:0]  cur_el_i,
  input  logic             el3_on_i,
  input  logic             ns_i,
  input  logic [CTL_W-1:0] l3_ctl_i,
  output logic             hit_o
);
  logic in_scope;
  logic [CTL_W-1:0] pass_code;

  always_comb begin
    in_scope  = el3_on_i && ((cur_el_i == EL_KERN) || (cur_el_i == EL_HYP));
    pass_code = ns_i ? NSEC_PASS : SEC_PASS;
    hit_o     = in_scope && (l3_ctl_i != pass_code);
  end
endmodule

// File: rtl/trc_verdict.sv
module trc_verdict
  import trc_gate_pkg::*;
(
  input  logic [EL_W-1:0] cur_el_i,
  input  logic            lower_hit_i,
  input  logic            upper_hit_i,
  output decision_t       dec_o
);
  always_comb begin
    dec_o.verd = VERD_ALLOW;
    dec_o.tgt  = EL_USER;
    if (cur_el_i == EL_USER) begin
      dec_o.verd = VERD_UNDEF;
    end else if (lower_hit_i) begin
      dec_o.verd = VERD_TRAP;
      dec_o.tgt  = EL_HYP;
    end else if (upper_hit_i) begin
      dec_o.verd = VERD_TRAP;
      dec_o.tgt  = EL_MON;
    end
  end
endmodule

// File: rtl/trc_access_gate.sv
module trc_access_gate
  import trc_gate_pkg::*;
#(
  parameter int unsigned      CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [CTL_W-1:0] SEC_PASS   = 2'b01,
  parameter logic [CTL_W-1:0] NSEC_PASS  = 2'b11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EL_W-1:0]    cur_el_i,
  input  logic               el2_on_i,
  input  logic               el3_on_i,
  input  logic               ns_i,
  input  logic [CTL_W-1:0]   l2_ctl_i,
  input  logic [CTL_W-1:0]   l3_ctl_i,
  output logic               allow_o,
  output logic               undef_o,
  output logic               trap_o,
  output logic [EL_W-1:0]    trap_el_o,
  output logic [CLASS_W-1:0] trap_class_o
);
  logic      lower_hit, upper_hit;
  decision_t dec;

  trc_lower_gate u_lower (
    .cur_el_i (cur_el_i),
    .el2_on_i (el2_on_i),
    .l2_ctl_i (l2_ctl_i),
    .hit_o    (lower_hit)
  );

  trc_upper_gate #(
    .SEC_PASS  (SEC_PASS),
    .NSEC_PASS (NSEC_PASS)
  ) u_upper (
    .cur_el_i (cur_el_i),
    .el3_on_i (el3_on_i),
    .ns_i     (ns_i),
    .l3_ctl_i (l3_ctl_i),
    .hit_o    (upper_hit)
  );

  trc_verdict u_verdict (
    .cur_el_i    (cur_el_i),
    .lower_hit_i (lower_hit),
    .upper_hit_i (upper_hit),
    .dec_o       (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o      <= 1'b0;
      undef_o      <= 1'b0;
      trap_o       <= 1'b0;
      trap_el_o    <= '0;
      trap_class_o <= '0;
    end else begin
      allow_o      <= (dec.verd == VERD_ALLOW);
      undef_o      <= (dec.verd == VERD_UNDEF);
      trap_o       <= (dec.verd == VERD_TRAP);
      trap_el_o    <= (dec.verd == VERD_TRAP) ? dec.tgt : '0;
      trap_class_o <= (dec.verd == VERD_TRAP) ? TRAP_CLASS : '0;
    end
  end
endmodule

// File: rtl/trc_access_gate_chk.sv
module trc_access_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cur_el_i,
  input logic       el2_on_i,
  input logic       el3_on_i,
  input logic       ns_i,
  input logic [1:0] l2_ctl_i,
  input logic [1:0] l3_ctl_i,
  input logic       allow_o,
  input logic       undef_o,
  input logic       trap_o,
  input logic [1:0] trap_el_o,
  input logic [5:0] trap_class_o
);
  logic live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> !allow_o && !undef_o && !trap_o && trap_el_o == 2'd0);

  a_r8_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> $countones({allow_o, undef_o, trap_o}) == 1);

  a_r8_trap_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_class_o == 6'h18 && trap_el_o != 2'd0);

  a_r8_idle_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> trap_class_o == 6'd0 && trap_el_o == 2'd0);

  a_r2_user_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cur_el_i) == 2'd0 |-> undef_o);

  a_r7_monitor_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cur_el_i) == 2'd3 |-> allow_o);

  a_r3_hyp_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cur_el_i) == 2'd1 && $past(el2_on_i) && !$past(l2_ctl_i[0])
      |-> trap_o && trap_el_o == 2'd2);

  a_r6_no_monitor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cur_el_i) == 2'd2 && !$past(el3_on_i) |-> allow_o);
endmodule

bind trc_access_gate trc_access_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cur_el_i     (cur_el_i),
  .el2_on_i     (el2_on_i),
  .el3_on_i     (el3_on_i),
  .ns_i         (ns_i),
  .l2_ctl_i     (l2_ctl_i),
  .l3_ctl_i     (l3_ctl_i),
  .allow_o      (allow_o),
  .undef_o      (undef_o),
  .trap_o       (trap_o),
  .trap_el_o    (trap_el_o),
  .trap_class_o (trap_class_o)
);

// File: tb/sim_trc_access_gate.sv
`timescale 1ns/1ps
module sim_trc_access_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cur_el = '0;
  logic       el2_on = 1'b0, el3_on = 1'b0, ns = 1'b0;
  logic [1:0] l2_ctl = '0, l3_ctl = '0;
  logic       allow, undef, trap;
  logic [1:0] trap_el;
  logic [5:0] trap_class;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  trc_access_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .cur_el_i(cur_el), .el2_on_i(el2_on),
    .el3_on_i(el3_on), .ns_i(ns), .l2_ctl_i(l2_ctl), .l3_ctl_i(l3_ctl),
    .allow_o(allow), .undef_o(undef), .trap_o(trap), .trap_el_o(trap_el),
    .trap_class_o(trap_class)
  );

  // packed expectation: {allow, undef, trap, trap_el[1:0], class[5:0]}
  function automatic logic [10:0] model(input int el, input bit e2, input bit e3,
                                        input bit s_ns, input int c2, input int c3);
    int pass;
    if (el == 0) return {3'b010, 2'd0, 6'd0};
    if (el == 3) return {3'b100, 2'd0, 6'd0};
    if (el == 1 && e2 && (c2 % 2 == 0)) return {3'b001, 2'd2, 6'h18};
    if (e3) begin
      pass = s_ns ? 3 : 1;
      if (c3 != pass) return {3'b001, 2'd3, 6'h18};
    end
    return {3'b100, 2'd0, 6'd0};
  endfunction

  function automatic string tag_of(input int el, input bit e2, input bit e3,
                                   input bit s_ns, input int c2);
    if (el == 0) return "R2";
    if (el == 3) return "R7";
    if (el == 1 && e2 && (c2 % 2 == 0)) return "R3";
    if (el == 2 && e2 && (c2 % 2 == 0)) return "R10";
    if (!e3) return "R6";
    return s_ns ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    logic [10:0] got;
    got = {allow, undef, trap, trap_el, trap_class};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_onehot();
    n_run++;
    if ($countones({allow, undef, trap}) != 1) begin
      n_fail++;
      $display("FAIL R8: verdict bits %b expected one-hot", {allow, undef, trap});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [10:0] prev_exp;
    string       prev_tag;
    int          k;
    repeat (3) @(negedge clk);
    check("R1", 11'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // inputs idle at el 0 during the first edge
    check("R2", model(0, 0, 0, 0, 0, 0));
    prev_exp = model(0, 0, 0, 0, 0, 0);
    prev_tag = "R2";
    k = 0;
    for (int el = 0; el < 4; el++)
      for (int e2 = 0; e2 < 2; e2++)
        for (int e3 = 0; e3 < 2; e3++)
          for (int s = 0; s < 2; s++)
            for (int c2 = 0; c2 < 4; c2++)
              for (int c3 = 0; c3 < 4; c3++) begin
                cur_el = el[1:0]; el2_on = e2[0]; el3_on = e3[0];
                ns = s[0]; l2_ctl = c2[1:0]; l3_ctl = c3[1:0];
                if (k % 29 == 0) begin
                  #1;
                  check("R9", prev_exp); // new inputs not yet visible
                end
                @(negedge clk);
                prev_exp = model(el, e2[0], e3[0], s[0], c2, c3);
                prev_tag = tag_of(el, e2[0], e3[0], s[0], c2);
                check(prev_tag, prev_exp);
                check_onehot();
                k++;
              end
    // explicit corners
    cur_el = 2'd1; el2_on = 1; l2_ctl = 2'b10; el3_on = 1; ns = 0; l3_ctl = 2'b00;
    @(negedge clk); check("R3", {3'b001, 2'd2, 6'h18});
    l2_ctl = 2'b01;
    @(negedge clk); check("R4", {3'b001, 2'd3, 6'h18});
    ns = 1; l3_ctl = 2'b11;
    @(negedge clk); check("R5", {3'b100, 2'd0, 6'd0});
    // asynchronous reset mid-run
    cur_el = 2'd0;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1", 11'd0);
    @(negedge clk); check("R1", 11'd0);
    rst_n = 1'b1;
    @(negedge clk); check("R2", {3'b010, 2'd0, 6'd0});
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule